// File: doc/BRIEF.md
# Single-Shot Sigma-Delta ADC Conversion Sequencer

This block is a host-side SPI master that runs one complete single-shot conversion on a serial sigma-delta converter. A user pulse on `start` makes it pull the chip select low and send two things over the serial link. The first is a one-byte command that addresses the converter's mode register. The second is a 24-bit mode word whose top three mode bits, 001, request a single conversion. The sequencer then keeps chip select low and watches the shared data-out/ready line. When that line falls, the result is ready. The block then sends the read-data command and shifts in the conversion word.

When the user asks for status at `start`, the mode word also sets the status-append bit, and the read frame grows by one trailing status byte. The low nibble of that byte names the converted channel. The result is presented together with a one-clock `done` pulse. If the ready line never falls, a timeout ends the frame and raises an error flag. The serial clock is derived from the system clock by a parameter and idles high between transfers.

Top module: `adc_single_ctrl`

## Requirements
- R1: After reset, `cs_n` and `sclk` are 1, and `busy`, `done` and `timeout_err` are 0.
- R2: A `start` while idle drives `cs_n` low and first sends the byte 0x08, MSB first. `din` changes only while `sclk` is low, after a falling edge. The converter samples it on the rising edge.
- R3: The next 24 bits sent are the mode word 0x280060, whose bits 23:21 are 001. When `status_en` was 1 at `start`, bit 20 is also set, giving 0x380060.
- R4: After the mode word, the block sends no clocks until `dout_rdy` falls while `cs_n` is low. It then sends the byte 0x58.
- R5: After 0x58, the block clocks in 24 data bits MSB first, sampled on rising `sclk`. It presents them on `result`. A plain frame therefore has 64 clocks.
- R6: With status enabled, the block clocks in 32 bits. `result` is the first 24 bits and `status` is the last 8, whose bits 3:0 carry the channel number. The frame has 72 clocks. Without status, `status` is 0.
- R7: `done` is high for exactly one clock. In that same clock `busy` is 0, `cs_n` is 1 and the outputs hold the new result.
- R8: If `dout_rdy` does not fall within TIMEOUT_CYC clocks of waiting, the block does the following. It raises `timeout_err`, pulses `done` with `result` and `status` at 0, and releases `cs_n`. The next `start` clears `timeout_err`.
- R9: `sclk` is 1 whenever `cs_n` is 1. Each `sclk` half-period lasts HALF_DIV system clocks (default 4).
- R10: A `start` while `busy` is 1 is ignored. The frame in progress keeps its bit count, and exactly one `done` follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin one conversion when idle |
| status_en | input | 1 | Request the trailing status byte for this conversion |
| busy | output | 1 | A conversion frame is in progress |
| done | output | 1 | One-clock pulse when the result is valid |
| result | output | 24 | Conversion data word |
| status | output | 8 | Status byte (channel in bits 3:0), 0 when not requested |
| timeout_err | output | 1 | The ready line never fell; cleared by the next start |
| sclk | output | 1 | Serial clock to the converter, idle high |
| din | output | 1 | Serial data to the converter |
| dout_rdy | input | 1 | Shared data-out / ready line from the converter |
| cs_n | output | 1 | Active-low chip select |

## Verification
The assertions assume that `dout_rdy` only falls during the wait phase after the converter has first held it high. They also assume that it changes at least two system clocks before each rising `sclk`, so that the synchronizer settles before sampling. The bench models the converter as follows. It holds the line high until it has seen all 32 write bits, and drops it a fixed delay later. It changes data bits one system clock after each falling `sclk`, which leaves a full half-period before the sample. The timeout case simply keeps the line high, and the stray-start case pulses `start` in the middle of the mode word.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_MODE,
        ST_WAIT,
        ST_RDCMD,
        ST_DATA
    } seq_state_e;

    localparam logic [7:0] CMD_SEL_MODE  = 8'h08;
    localparam logic [7:0] CMD_READ_DATA = 8'h58;

endpackage

// File: rtl/adc_sclk_div.sv
module adc_sclk_div #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sclk,
    output logic fall_en,
    output logic rise_en
);

    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          sclk;
    } div_t;

    div_t div_d, div_q;
    logic wrap;

    always_comb begin
        div_d = div_q;
        wrap  = run && (div_q.cnt == LAST);
        if (!run) begin
            div_d.cnt  = '0;
            div_d.sclk = 1'b1;
        end else if (wrap) begin
            div_d.cnt  = '0;
            div_d.sclk = ~div_q.sclk;
        end else begin
            div_d.cnt = div_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q.cnt  <= '0;
            div_q.sclk <= 1'b1;
        end else begin
            div_q <= div_d;
        end
    end

    assign sclk    = div_q.sclk;
    assign fall_en = wrap & div_q.sclk;
    assign rise_en = wrap & ~div_q.sclk;

    // R9
    sclk_idle_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> sclk);

endmodule

// File: rtl/adc_spi_shift.sv
module adc_spi_shift #(
    parameter int MAX_W = 32,
    localparam int LEN_W = $clog2(MAX_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LEN_W-1:0] len,
    input  logic [MAX_W-1:0] tx_data,
    input  logic             fall_en,
    input  logic             rise_en,
    input  logic             miso,
    output logic             active,
    output logic             mosi,
    output logic             done,
    output logic [MAX_W-1:0] rx_data
);

    typedef struct packed {
        logic             active;
        logic [LEN_W-1:0] cnt;
        logic [LEN_W-1:0] len;
        logic [MAX_W-1:0] tx;
        logic [MAX_W-1:0] rx;
        logic             mosi;
        logic             done;
    } sh_t;

    sh_t sh_d, sh_q;
    logic [LEN_W-1:0] pad;

    always_comb begin
        sh_d      = sh_q;
        sh_d.done = 1'b0;
        pad       = LEN_W'(MAX_W) - len;
        if (load) begin
            sh_d.active = 1'b1;
            sh_d.cnt    = '0;
            sh_d.len    = len;
            sh_d.tx     = tx_data << pad;
            sh_d.rx     = '0;
        end else if (sh_q.active) begin
            if (fall_en) begin
                sh_d.mosi = sh_q.tx[MAX_W-1];
                sh_d.tx   = {sh_q.tx[MAX_W-2:0], 1'b0};
            end
            if (rise_en) begin
                sh_d.rx = {sh_q.rx[MAX_W-2:0], miso};
                if (sh_q.cnt == sh_q.len - 1'b1) begin
                    sh_d.active = 1'b0;
                    sh_d.done   = 1'b1;
                end else begin
                    sh_d.cnt = sh_q.cnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q      <= '0;
            sh_q.mosi <= 1'b1;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign active  = sh_q.active;
    assign mosi    = sh_q.mosi;
    assign done    = sh_q.done;
    assign rx_data = sh_q.rx;

    // R5
    shift_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (sh_q.cnt < sh_q.len));

    // R5
    shift_done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !active);

endmodule

// File: rtl/adc_single_ctrl.sv
module adc_single_ctrl
    import adc_ctrl_pkg::*;
#(
    parameter int          HALF_DIV    = 4,
    parameter int          TIMEOUT_CYC = 1000,
    parameter int          REG_W       = 24,
    parameter int          DATA_W      = 24,
    parameter int          STAT_W      = 8,
    parameter logic [23:0] MODE_WORD   = 24'h280060,
    parameter int          STAT_BIT    = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              status_en,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] result,
    output logic [STAT_W-1:0] status,
    output logic              timeout_err,
    output logic              sclk,
    output logic              din,
    input  logic              dout_rdy,
    output logic              cs_n
);

    localparam int FRAME_W = DATA_W + STAT_W;
    localparam int MAX_W   = (FRAME_W > REG_W) ? FRAME_W : REG_W;
    localparam int LEN_W   = $clog2(MAX_W + 1);
    localparam int TO_W    = $clog2(TIMEOUT_CYC + 1);
    localparam logic [TO_W-1:0] TO_LAST = TO_W'(TIMEOUT_CYC - 1);

    typedef struct packed {
        seq_state_e        state;
        logic              cs_n;
        logic [TO_W-1:0]   to_cnt;
        logic              stat_en;
        logic [DATA_W-1:0] result;
        logic [STAT_W-1:0] status;
        logic              done;
        logic              err;
        logic              sync1;
        logic              sync2;
        logic              rdy_prev;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic             ld;
    logic [LEN_W-1:0] ld_len;
    logic [MAX_W-1:0] ld_data;
    logic [REG_W-1:0] mode_eff;
    logic             sh_active, sh_done, sh_mosi;
    logic [MAX_W-1:0] sh_rx;
    logic             fall_en, rise_en;

    adc_sclk_div #(.HALF_DIV(HALF_DIV)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (sh_active),
        .sclk    (sclk),
        .fall_en (fall_en),
        .rise_en (rise_en)
    );

    adc_spi_shift #(.MAX_W(MAX_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (ld),
        .len     (ld_len),
        .tx_data (ld_data),
        .fall_en (fall_en),
        .rise_en (rise_en),
        .miso    (ctl_q.sync2),
        .active  (sh_active),
        .mosi    (sh_mosi),
        .done    (sh_done),
        .rx_data (sh_rx)
    );

    always_comb begin
        ctl_d          = ctl_q;
        ctl_d.done     = 1'b0;
        ctl_d.sync1    = dout_rdy;
        ctl_d.sync2    = ctl_q.sync1;
        ctl_d.rdy_prev = ctl_q.sync2;
        ld             = 1'b0;
        ld_len         = '0;
        ld_data        = '0;
        mode_eff       = MODE_WORD | (REG_W'(ctl_q.stat_en) << STAT_BIT);
        case (ctl_q.state)
            ST_IDLE: begin
                if (start) begin
                    ctl_d.cs_n    = 1'b0;
                    ctl_d.stat_en = status_en;
                    ctl_d.err     = 1'b0;
                    ld            = 1'b1;
                    ld_len        = LEN_W'(8);
                    ld_data       = MAX_W'(CMD_SEL_MODE);
                    ctl_d.state   = ST_CMD;
                end
            end
            ST_CMD: begin
                if (sh_done) begin
                    ld          = 1'b1;
                    ld_len      = LEN_W'(REG_W);
                    ld_data     = MAX_W'(mode_eff);
                    ctl_d.state = ST_MODE;
                end
            end
            ST_MODE: begin
                if (sh_done) begin
                    ctl_d.to_cnt = '0;
                    ctl_d.state  = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (ctl_q.rdy_prev && !ctl_q.sync2) begin
                    ld          = 1'b1;
                    ld_len      = LEN_W'(8);
                    ld_data     = MAX_W'(CMD_READ_DATA);
                    ctl_d.state = ST_RDCMD;
                end else if (ctl_q.to_cnt == TO_LAST) begin
                    ctl_d.err    = 1'b1;
                    ctl_d.done   = 1'b1;
                    ctl_d.result = '0;
                    ctl_d.status = '0;
                    ctl_d.cs_n   = 1'b1;
                    ctl_d.state  = ST_IDLE;
                end else begin
                    ctl_d.to_cnt = ctl_q.to_cnt + 1'b1;
                end
            end
            ST_RDCMD: begin
                if (sh_done) begin
                    ld          = 1'b1;
                    ld_len      = ctl_q.stat_en ? LEN_W'(FRAME_W) : LEN_W'(DATA_W);
                    ctl_d.state = ST_DATA;
                end
            end
            ST_DATA: begin
                if (sh_done) begin
                    if (ctl_q.stat_en) begin
                        ctl_d.result = sh_rx[FRAME_W-1:STAT_W];
                        ctl_d.status = sh_rx[STAT_W-1:0];
                    end else begin
                        ctl_d.result = sh_rx[DATA_W-1:0];
                        ctl_d.status = '0;
                    end
                    ctl_d.done  = 1'b1;
                    ctl_d.cs_n  = 1'b1;
                    ctl_d.state = ST_IDLE;
                end
            end
            default: ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q          <= '0;
            ctl_q.state    <= ST_IDLE;
            ctl_q.cs_n     <= 1'b1;
            ctl_q.sync1    <= 1'b1;
            ctl_q.sync2    <= 1'b1;
            ctl_q.rdy_prev <= 1'b1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy        = (ctl_q.state != ST_IDLE);
    assign done        = ctl_q.done;
    assign result      = ctl_q.result;
    assign status      = ctl_q.status;
    assign timeout_err = ctl_q.err;
    assign cs_n        = ctl_q.cs_n;
    assign din         = sh_mosi;

    // R9
    sclk_cs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> sclk);

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && cs_n && $past(busy)));

    // R2
    din_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(din) |-> !sclk);

    // R8
    err_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_err) |-> $past(ctl_q.state == ST_WAIT));

    // R4
    no_clock_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == ST_WAIT) |-> sclk);

endmodule

// File: tb/tb_adc_single_ctrl.sv
module tb_adc_single_ctrl;

    localparam int HALF_DIV = 4;
    localparam int CONV_DLY = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        status_en = 1'b0;
    logic        busy, done, timeout_err, sclk, din, cs_n;
    logic        dout_rdy = 1'b1;
    logic [23:0] result;
    logic [7:0]  status;

    always #10 clk = ~clk;

    adc_single_ctrl dut (
        .clk(clk), .rst_n(rst_n), .start(start), .status_en(status_en),
        .busy(busy), .done(done), .result(result), .status(status),
        .timeout_err(timeout_err), .sclk(sclk), .din(din),
        .dout_rdy(dout_rdy), .cs_n(cs_n)
    );

    int n_cmp = 0;
    int n_bad = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // converter model, evaluated on falling clk
    logic [63:0] s_rx = '0;
    logic [63:0] s_tx = '0;
    logic [63:0] s_data = '0;
    int          s_bits = 0;
    int          s_last = 0;
    int          s_conv = -1;
    bit          s_suppress = 0;
    logic        s_sclk_prev = 1'b1;
    logic [7:0]  got_cmd = '0, got_rd = '0;
    logic [23:0] got_mode = '0;

    always @(negedge clk) begin
        if (cs_n) begin
            s_bits   = 0;
            s_conv   = -1;
            dout_rdy <= 1'b1;
        end else begin
            if (sclk && !s_sclk_prev) begin
                s_rx = {s_rx[62:0], din};
                s_bits++;
                s_last = s_bits;
                if (s_bits == 32) begin
                    got_cmd  = s_rx[31:24];
                    got_mode = s_rx[23:0];
                    s_conv   = CONV_DLY;
                end
                if (s_bits == 40) begin
                    got_rd = s_rx[7:0];
                    s_tx   = s_data;
                end
            end
            if (!sclk && s_sclk_prev && s_bits >= 40) begin
                dout_rdy <= s_tx[63];
                s_tx = {s_tx[62:0], 1'b0};
            end
            if (s_conv > 0) s_conv--;
            else if (s_conv == 0) begin
                if (!s_suppress) dout_rdy <= 1'b0;
                s_conv = -1;
            end
        end
        s_sclk_prev = sclk;
    end

    // scoreboard
    typedef struct packed {
        logic [23:0] res;
        logic [7:0]  st;
        logic        err;
    } exp_t;
    exp_t exp_q[$];

    always @(negedge clk) begin
        if (rst_n && done) begin
            if (exp_q.size() == 0) begin
                chk(0, "R10", "unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(result == e.res, e.err ? "R8" : "R5", "result", result, e.res);
                chk(status == e.st, "R6", "status", status, e.st);
                chk(timeout_err == e.err, "R8", "timeout_err", timeout_err, e.err);
                chk(!busy && cs_n, "R7", "busy/cs_n at done", {busy, cs_n}, 2'b01);
            end
        end
    end

    task automatic run_conv(input logic [23:0] d, input logic [7:0] st,
                            input bit sen, input bit no_rdy,
                            input bit measure, input bit stray);
        exp_t e;
        int   n;
        s_suppress = no_rdy;
        s_data     = sen ? {d, st, 32'h0} : {d, 40'h0};
        e.res = no_rdy ? 24'h0 : d;
        e.st  = (no_rdy || !sen) ? 8'h0 : st;
        e.err = no_rdy;
        exp_q.push_back(e);
        @(negedge clk);
        start     = 1'b1;
        status_en = sen;
        @(negedge clk);
        start = 1'b0;
        chk(busy && !cs_n, "R2", "busy/cs_n after start", {busy, cs_n}, 2'b10);
        if (measure) begin
            while (sclk) @(negedge clk);
            n = 0;
            while (!sclk) begin
                @(negedge clk);
                n++;
            end
            chk(n == HALF_DIV, "R9", "sclk low half-period", n, HALF_DIV);
        end
        if (stray) begin
            repeat (100) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        do @(negedge clk); while (!done);
        @(negedge clk);
        chk(got_cmd == 8'h08, "R2", "command byte", got_cmd, 8'h08);
        chk(got_mode == (sen ? 24'h380060 : 24'h280060), "R3", "mode word",
            got_mode, sen ? 24'h380060 : 24'h280060);
        if (no_rdy) begin
            chk(s_last == 32, "R8", "frame bits", s_last, 32);
        end else begin
            chk(got_rd == 8'h58, "R4", "read command", got_rd, 8'h58);
            chk(s_last == (sen ? 72 : 64), sen ? "R6" : "R5", "frame bits",
                s_last, sen ? 72 : 64);
        end
        chk(exp_q.size() == 0, "R10", "pending items", exp_q.size(), 0);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "R1", "watchdog expired", 1, 0);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(cs_n == 1'b1, "R1", "cs_n", cs_n, 1);
        chk(sclk == 1'b1, "R1", "sclk", sclk, 1);
        chk(busy == 1'b0, "R1", "busy", busy, 0);
        chk(done == 1'b0, "R1", "done", done, 0);
        chk(timeout_err == 1'b0, "R1", "timeout_err", timeout_err, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        run_conv(24'hA5C3F1, 8'h00, 0, 0, 1, 0);   // R5 plain read, R9 timing
        run_conv(24'h000001, 8'h83, 1, 0, 0, 0);   // R6 status, channel 3
        run_conv(24'hFFFFFF, 8'h05, 1, 0, 0, 0);   // R6 all ones
        run_conv(24'h800000, 8'h00, 0, 0, 0, 0);   // R5 MSB only
        run_conv(24'h000000, 8'h00, 0, 1, 0, 0);   // R8 timeout
        chk(timeout_err == 1'b1, "R8", "error held after timeout", timeout_err, 1);
        chk(sclk == 1'b1, "R9", "sclk idle after timeout", sclk, 1);
        run_conv(24'h123456, 8'h0A, 1, 0, 0, 0);   // R8 error cleared by start
        run_conv(24'h5A5A5A, 8'h00, 0, 0, 0, 1);   // R10 stray start
        repeat (5) @(negedge clk);
        chk(busy == 1'b0, "R10", "idle after stray start", busy, 0);
        finish_run();
    end

endmodule